// File: doc/BRIEF.md
# AGC Gain Dwell Controller

This block chooses the gain setting of a receiver front-end from one comparator bit, `pwr_above`, which is high when received power is over the switching threshold. Power over the threshold selects low gain at once. When power drops under the threshold, low gain is kept for a dwell interval of 2^N reference clock cycles. High gain is chosen only if power is still under the threshold when that interval ends. Short low-power stretches inside the data, such as the zeros of on-off keyed symbols, therefore do not toggle the gain.

The dwell exponent N is held in an 8-bit configuration register. The register is written through a small write port and is selected at a fixed address. It comes out of reset holding 13. Exponents above the supported maximum are clamped to that maximum. The block drives the gain state and a flag that is high while the dwell timer is holding low gain.

Top module: `agc_dwell_ctrl`

## Requirements
- R1: After reset the outputs are `gain_high`=0 and `dwell_active`=0. The exponent register holds 13, so the first dwell lasts 8192 cycles.
- R2: If `pwr_above` is sampled high on a clock edge, `gain_high` and `dwell_active` are both 0 after that edge. This holds from any state.
- R3: The first edge that samples `pwr_above` low while gain is low starts a dwell. `dwell_active` is then 1 for exactly 2^N cycles, and `gain_high` stays 0 during that time.
- R4: On the edge that ends the dwell with `pwr_above` still low, `gain_high` becomes 1. It stays 1 for as long as `pwr_above` remains low.
- R5: If `pwr_above` returns high during a dwell, the dwell is cancelled. The next fall starts a new dwell of the full 2^N cycles.
- R6: A write with `cfg_we`=1 and `cfg_addr`=0xA loads `cfg_wdata` as the exponent. A write to any other address leaves the exponent unchanged.
- R7: An exponent greater than MAX_EXP (default 16) acts as MAX_EXP. For example, 0xFF gives a dwell of 65536 cycles.
- R8: An exponent of 0 gives a dwell of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_above | input | 1 | Comparator output, high when power is over the threshold |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| gain_high | output | 1 | 1 = high gain selected, 0 = low gain |
| dwell_active | output | 1 | Low gain is being held by the dwell timer |

## Verification
The hardest case to reach from the ports is the clamp on large exponents, because it is only visible as a dwell of 65536 cycles. The bench writes 0xFF and counts every cycle of `dwell_active` until `gain_high` rises. It also reaches a cancel in the middle of a dwell by raising `pwr_above` partway through. It then checks that the next fall restarts the count from zero rather than continuing the old one.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    GS_LOW  = 2'd0,
    GS_HOLD = 2'd1,
    GS_HIGH = 2'd2
  } gain_state_e;
endpackage

// File: rtl/agc_dwell_reg.sv
module agc_dwell_reg #(
  parameter int ADDR_W    = 4,
  parameter int REG_ADDR  = 10,
  parameter int RESET_VAL = 13,
  parameter int MAX_EXP   = 16,
  localparam int EXP_W    = $clog2(MAX_EXP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [EXP_W-1:0] exp_eff
);
  logic [7:0] reg_q, reg_d;
  logic       hit;

  assign hit = we && (addr == ADDR_W'(REG_ADDR));

  always_comb begin
    reg_d = reg_q;
    if (hit) reg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= 8'(RESET_VAL);
    else        reg_q <= reg_d;
  end

  // clamp to the deepest supported exponent
  always_comb begin
    if (reg_q > 8'(MAX_EXP)) exp_eff = EXP_W'(MAX_EXP);
    else                     exp_eff = EXP_W'(reg_q);
  end

  a_r7_exp_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    exp_eff <= EXP_W'(MAX_EXP));
  a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wdata <= 8'(MAX_EXP)) |=> (exp_eff == EXP_W'($past(wdata))));
endmodule

// File: rtl/agc_dwell_timer.sv
module agc_dwell_timer #(
  parameter int MAX_EXP = 16,
  localparam int EXP_W  = $clog2(MAX_EXP + 1),
  localparam int CNT_W  = MAX_EXP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             clr,
  input  logic [EXP_W-1:0] exp_eff,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  assign limit = CNT_W'(1) << exp_eff;
  assign done  = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (start)                    cnt_d = CNT_W'(1);
    else if (clr)                 cnt_d = '0;
    else if (run && cnt_q < limit) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt_q != '0);
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !start) |=> cnt_q == '0);
endmodule

// File: rtl/agc_gain_fsm.sv
module agc_gain_fsm
  import agc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_above,
  input  logic tmr_done,
  output logic tmr_start,
  output logic tmr_run,
  output logic tmr_clr,
  output logic gain_high,
  output logic dwell_active
);
  gain_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    tmr_start = 1'b0;
    tmr_run   = 1'b0;
    tmr_clr   = 1'b0;
    if (pwr_above) begin
      st_d    = GS_LOW;
      tmr_clr = 1'b1;
    end else begin
      unique case (st_q)
        GS_LOW: begin
          st_d      = GS_HOLD;
          tmr_start = 1'b1;
        end
        GS_HOLD: begin
          if (tmr_done) begin
            st_d    = GS_HIGH;
            tmr_clr = 1'b1;
          end else begin
            tmr_run = 1'b1;
          end
        end
        GS_HIGH: st_d = GS_HIGH;
        default: st_d = GS_LOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_LOW;
    else        st_q <= st_d;
  end

  assign gain_high    = (st_q == GS_HIGH);
  assign dwell_active = (st_q == GS_HOLD);

  a_r2_above_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_above |=> (!gain_high && !dwell_active));
  a_r4_high_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_high && !pwr_above) |=> gain_high);
  a_r3_rise_after_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_high) |-> $past(dwell_active));
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gain_high, dwell_active}));
endmodule

// File: rtl/agc_dwell_ctrl.sv
module agc_dwell_ctrl #(
  parameter int ADDR_W    = 4,
  parameter int REG_ADDR  = 10,
  parameter int RESET_EXP = 13,
  parameter int MAX_EXP   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_above,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic              gain_high,
  output logic              dwell_active
);
  localparam int EXP_W = $clog2(MAX_EXP + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [EXP_W-1:0] exp_eff;
  logic tmr_start, tmr_run, tmr_clr, tmr_done;

  agc_dwell_reg #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
    .RESET_VAL(RESET_EXP), .MAX_EXP(MAX_EXP)
  ) u_reg (
    .clk(clk), .rst_n(rst_core_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .exp_eff(exp_eff)
  );

  agc_dwell_timer #(.MAX_EXP(MAX_EXP)) u_tmr (
    .clk(clk), .rst_n(rst_core_n), .start(tmr_start), .run(tmr_run),
    .clr(tmr_clr), .exp_eff(exp_eff), .done(tmr_done)
  );

  agc_gain_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n), .pwr_above(pwr_above),
    .tmr_done(tmr_done), .tmr_start(tmr_start), .tmr_run(tmr_run),
    .tmr_clr(tmr_clr), .gain_high(gain_high), .dwell_active(dwell_active)
  );
endmodule

// File: tb/agc_dwell_ctrl_tb.sv
module agc_dwell_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_above = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic gain_high, dwell_active;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  agc_dwell_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_above(pwr_above), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .gain_high(gain_high), .dwell_active(dwell_active)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drop power and count cycles with dwell_active until gain_high rises
  task automatic measure_dwell(string req, int expect_len);
    int n = 0;
    int gain_during = 0;
    @(negedge clk);
    pwr_above = 1'b0;
    @(negedge clk);
    while (dwell_active === 1'b1 && n < 70000) begin
      n++;
      if (gain_high !== 1'b0) gain_during++;
      @(negedge clk);
    end
    check({req, " dwell length"}, n, expect_len);
    check({req, " gain low in dwell"}, gain_during, 0);
    check({req, " gain high after dwell"}, int'(gain_high), 1);
  endtask

  task automatic raise_power(string req);
    @(negedge clk);
    pwr_above = 1'b1;
    @(negedge clk);
    check({req, " gain low"}, int'(gain_high), 0);
    check({req, " dwell idle"}, int'(dwell_active), 0);
  endtask

  task automatic t_reset;
    check("R1 gain_high", int'(gain_high), 0);
    check("R1 dwell_active", int'(dwell_active), 0);
    measure_dwell("R1 default exp 13", 8192);
    repeat (20) @(negedge clk);
    check("R4 stays high", int'(gain_high), 1);
    raise_power("R2 from high");
  endtask

  task automatic t_cancel;
    write_reg(4'hA, 8'd3);
    measure_dwell("R6 exp 3", 8);
    raise_power("R2 after R6");
    @(negedge clk);
    pwr_above = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 mid dwell active", int'(dwell_active), 1);
    raise_power("R5 cancel");
    measure_dwell("R5 restart", 8);
    raise_power("R2 after R5");
  endtask

  task automatic t_addr;
    write_reg(4'h5, 8'd0);
    measure_dwell("R6 other addr ignored", 8);
    raise_power("R2 after addr");
  endtask

  task automatic t_zero;
    write_reg(4'hA, 8'd0);
    measure_dwell("R8 exp 0", 1);
    raise_power("R2 after R8");
  endtask

  task automatic t_sat;
    write_reg(4'hA, 8'hFF);
    measure_dwell("R7 clamp", 65536);
    raise_power("R2 after R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cancel();
    t_addr();
    t_zero();
    t_sat();
    done_flag = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule